// File: doc/BRIEF.md
# Accumulator CPU Fetch-Execute Sequencer

This block is the control and datapath core of a small single-accumulator processor. It keeps a program counter, a memory address register, a memory buffer register, an instruction register and one accumulator. It works against an external single-port synchronous memory that holds both program words and data. That memory is reached only through the address register (for addressing) and the buffer register (for data in both directions).

Every instruction starts with the same four-step fetch:
- the address register takes the program counter;
- the program counter advances by one;
- the buffer register captures the addressed word;
- the instruction register takes the buffer register.

After the fetch, a per-opcode execute sequence runs and control then returns to the fetch. The opcodes are load, add, store, jump, conditional branch and halt. The branch condition arrives on a single input bit, so an external flag unit can drive it.

Top module: `acc_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the accumulator and the instruction register, holds `halted` and `mem_we` low, and restarts at the first fetch step, so the first word fetched is at address 0.
- R2: Each fetch reads the word at the current program counter through `mem_addr`, and the program counter advances by exactly one during that fetch.
- R3: An instruction word is 16 bits: the opcode is bits 15:12 and the address operand is bits 11:0. The opcodes are 0 load, 1 add, 2 store, 3 jump, 4 branch and 15 halt. Memory reads return data one cycle after the address is presented.
- R4: Load (opcode 0) sets the accumulator to the memory word at the operand address and takes 8 cycles.
- R5: Add (opcode 1) sets the accumulator to the accumulator plus the memory word at the operand address, wrapping modulo 2^16, and takes 8 cycles.
- R6: Store (opcode 2) writes the accumulator to the operand address with one `mem_we` pulse, leaves the accumulator unchanged and takes 6 cycles. A fetch that immediately follows sees the new word.
- R7: Jump (opcode 3) loads the program counter with the operand address and takes 5 cycles.
- R8: Branch (opcode 4), sampled in its execute cycle, loads the program counter with the operand when `cond` is 1. When `cond` is 0 it leaves the program counter at the value incremented during the fetch. It takes 5 cycles either way.
- R9: Halt (opcode 15) takes 5 cycles and then parks the sequencer with `halted` high. While parked, the program counter and the accumulator stay constant and no memory write occurs.
- R10: Opcodes 5 to 14 take 5 cycles, change neither the accumulator nor the memory, and fall through to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | 1 | Branch condition bit |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_we | output | 1 | Memory write enable |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| halted | output | 1 | Sequencer parked after a halt |

## Verification
The memory port serves two functions: the write of a store and the read of the next fetch. These meet back to back on the same memory word when a store overwrites the instruction that directly follows it. A program loads a halt word, stores it over the word after the store (which originally held a jump back to 0), and must then halt rather than loop. The result is judged on the final program counter, on the accumulator and on the exact cycle count to `halted`. An add with carry out of bit 15 is also run, and the accumulator is expected to wrap rather than saturate.

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-OPW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] acc,
  output logic [DW-OPW-1:0] pc,
  output logic          halted
);
  localparam int AW = DW - OPW;
  localparam logic [OPW-1:0] OP_LD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(2);
  localparam logic [OPW-1:0] OP_JMP = OPW'(3);
  localparam logic [OPW-1:0] OP_BR  = OPW'(4);
  localparam logic [OPW-1:0] OP_HLT = {OPW{1'b1}};

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_F4, S_EX, S_WAIT, S_CAP, S_ALU, S_WR, S_HALT
  } step_t;

  step_t          st;
  logic [AW-1:0]  mar;
  logic [DW-1:0]  mbr, ir;
  logic [OPW-1:0] op;
  logic [AW-1:0]  opnd;

  assign op        = ir[DW-1:AW];
  assign opnd      = ir[AW-1:0];
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (st == S_WR);
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_F1;
      pc  <= '0;
      acc <= '0;
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
    end else begin
      case (st)
        S_F1: begin mar <= pc;        st <= S_F2; end
        S_F2: begin pc  <= pc + 1'b1; st <= S_F3; end
        S_F3: begin mbr <= mem_rdata; st <= S_F4; end
        S_F4: begin ir  <= mbr;       st <= S_EX; end
        S_EX: begin
          case (op)
            OP_LD, OP_ADD: begin mar <= opnd; st <= S_WAIT; end
            OP_ST:  begin mar <= opnd; mbr <= acc; st <= S_WR; end
            OP_JMP: begin pc <= opnd; st <= S_F1; end
            OP_BR:  begin
              if (cond) pc <= opnd;
              st <= S_F1;
            end
            OP_HLT: st <= S_HALT;
            default: st <= S_F1;
          endcase
        end
        S_WAIT: st <= S_CAP;
        S_CAP:  begin mbr <= mem_rdata; st <= S_ALU; end
        S_ALU:  begin
          acc <= (op == OP_ADD) ? acc + mbr : mbr;
          st  <= S_F1;
        end
        S_WR:   st <= S_F1;
        S_HALT: st <= S_HALT;
        default: st <= S_F1;
      endcase
    end
  end

  // R1: after reset, the first fetch reads address 0
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !mem_we && !halted));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_F2) |-> (mem_addr == pc));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_F2) |=> (pc == $past(pc) + 1'b1));

  p_ir_split_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_F4) |=> (ir == $past(mbr)));

  p_store_data_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));

  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && op == OP_JMP) |=> (pc == $past(opnd)));

  p_branch_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && op == OP_BR && cond) |=> (pc == $past(opnd)));

  p_branch_not_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && op == OP_BR && !cond) |=> $stable(pc));

  p_halt_parked_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc) && !mem_we));
endmodule

// File: tb/sim_acc_seq.sv
module sim_acc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cond = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] acc;
  logic [11:0] pc;
  logic        halted;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  acc_seq u0 (
    .clk(clk), .rst(rst), .cond(cond), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .acc(acc), .pc(pc), .halted(halted)
  );

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      writes <= writes + 1;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(output int cyc);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    writes = 0;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
  endtask

  // {a, b, a+b mod 2^16}
  localparam logic [47:0] VEC [5] = '{
    {16'h1234, 16'h1111, 16'h2345},
    {16'hFFFF, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h7FFF, 16'h0002, 16'h8001}
  };

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int w0;
    logic [11:0] pc0;
    logic [15:0] a0;

    clear_mem();
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 we", 32'(mem_we), 0);

    // R3 R4 R5 R6 R9: load, add, store, halt walked over a table
    for (int v = 0; v < 5; v++) begin
      clear_mem();
      mem[0] = 16'h0040; mem[1] = 16'h1041; mem[2] = 16'h2042; mem[3] = 16'hF000;
      mem[8'h40] = VEC[v][47:32];
      mem[8'h41] = VEC[v][31:16];
      run(cyc);
      chk("R5 acc sum", 32'(acc), 32'(VEC[v][15:0]));
      chk("R6 stored", 32'(mem[8'h42]), 32'(VEC[v][15:0]));
      chk("R6 one write", writes, 1);
      chk("R4 R5 R6 R9 cycles", cyc, 27);
      chk("R2 pc after halt", 32'(pc), 4);
    end

    // R4 load alone, R1 first fetch at 0
    clear_mem();
    mem[0] = 16'h0050; mem[1] = 16'hF000; mem[8'h50] = 16'hBEEF;
    run(cyc);
    chk("R4 load", 32'(acc), 32'hBEEF);
    chk("R4 cycles", cyc, 13);

    // R7 jump skips the load at address 1
    clear_mem();
    mem[0] = 16'h3005; mem[1] = 16'h0040; mem[5] = 16'hF000; mem[8'h40] = 16'h5555;
    run(cyc);
    chk("R7 acc untouched", 32'(acc), 0);
    chk("R7 pc", 32'(pc), 6);
    chk("R7 cycles", cyc, 10);

    // R8 branch taken
    clear_mem();
    mem[0] = 16'h4003; mem[1] = 16'hF000; mem[3] = 16'hF000;
    cond = 1'b1;
    run(cyc);
    chk("R8 taken pc", 32'(pc), 4);
    chk("R8 taken cycles", cyc, 10);

    // R8 branch not taken
    cond = 1'b0;
    run(cyc);
    chk("R8 not taken pc", 32'(pc), 2);
    chk("R8 not taken cycles", cyc, 10);

    // R10 undefined opcodes fall through
    for (int o = 5; o < 15; o++) begin
      clear_mem();
      mem[0] = 16'h0040; mem[1] = {4'(o), 12'h041}; mem[2] = 16'hF000;
      mem[8'h40] = 16'h0A0A; mem[8'h41] = 16'h0101;
      run(cyc);
      chk("R10 acc", 32'(acc), 32'h0A0A);
      chk("R10 no write", writes, 0);
      chk("R10 cycles", cyc, 18);
    end

    // R6 store overwrites the next instruction (jump 0) with halt
    clear_mem();
    mem[0] = 16'h0040; mem[1] = 16'h2002; mem[2] = 16'h3000; mem[8'h40] = 16'hF000;
    run(cyc);
    chk("R6 back-to-back fetch sees store", 32'(pc), 3);
    chk("R6 acc kept", 32'(acc), 32'hF000);
    chk("R6 cycles", cyc, 19);

    // R9 parked state holds steady
    pc0 = pc; a0 = acc; w0 = writes;
    cond = 1'b1;
    for (int k = 0; k < 20; k++) begin @(posedge clk); @(negedge clk); end
    chk("R9 still halted", 32'(halted), 1);
    chk("R9 pc stable", 32'(pc), 32'(pc0));
    chk("R9 acc stable", 32'(acc), 32'(a0));
    chk("R9 no writes", writes, w0);

    // R1 reset in the middle of a run
    clear_mem();
    mem[0] = 16'h0040; mem[1] = 16'h3000; mem[8'h40] = 16'h1357;
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 11; k++) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1; @(posedge clk); @(negedge clk);
    chk("R1 mid-run pc", 32'(pc), 0);
    chk("R1 mid-run acc", 32'(acc), 0);
    chk("R1 mid-run halted", 32'(halted), 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule